// File: doc/BRIEF.md
# Conditional Branch Resolver

This execute-stage block settles conditional branches for an out-of-order integer core. Decoded branches arrive on a valid/ready stream, each with two resolved operands, its PC, an immediate, the direction that fetch predicted, a sequence number and two physical register tags. The instruction lands in a small input queue with a bypass path. The block then compares the operands, works out the real direction and computes the target as PC plus immediate.

When the head instruction is first presented to writeback, the block pulses a predictor-update notification. If the real direction disagrees with the carried prediction, it also pulses a redirect notification. Both notifications carry the real direction, the taken target and the fall-through address, so the consumer can choose where fetch should go. A sent flag makes sure that a head held by a writeback stall publishes its notifications only once. The result leaves on a valid/ready output with the sequence number and tags passed through unchanged and the register write-enable held low.

Top module: `brx_unit`

## Requirements
- R1: The branch kind code `in_kind` selects the condition: 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal. Codes 2 and 3 always resolve as not taken.
- R2: `out_target` and `nt_target` equal PC plus immediate, modulo 2^XLEN. `nt_fall` equals PC plus 4.
- R3: `rdr_valid` pulses only when the real direction differs from the instruction's predicted bit, and only in the cycle where that instruction first appears at the output.
- R4: `upd_valid` pulses exactly once for every branch, in the cycle where it first appears at the output, whether or not it was mispredicted.
- R5: While a head instruction is held (`out_valid` high and `out_ready` low), neither notification repeats. The held state clears when the output handshake completes.
- R6: When the queue is empty, an arriving instruction appears at the output in the same cycle. Instructions leave in arrival order, and a held output keeps its payload stable.
- R7: `in_ready` is low exactly when DEPTH instructions are stored in the queue.
- R8: `out_seq`, `out_ptag` and `out_pptag` equal the values that came with the instruction, and `out_wen` is always 0.
- R9: After reset, `out_valid`, `rdr_valid` and `upd_valid` are 0 and `in_ready` is 1.
- R10: `out_taken` and `nt_taken` carry the real branch direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch offered by issue |
| in_ready | output | 1 | Queue can accept a branch |
| in_kind | input | 3 | Branch condition code |
| in_op_a | input | XLEN | First operand |
| in_op_b | input | XLEN | Second operand |
| in_pc | input | XLEN | Branch PC |
| in_imm | input | XLEN | Sign-extended offset |
| in_pred | input | 1 | Direction predicted at fetch |
| in_seq | input | SEQ_W | Sequence number |
| in_ptag | input | TAG_W | Destination physical tag |
| in_pptag | input | TAG_W | Previous physical tag |
| out_valid | output | 1 | Result offered to writeback |
| out_ready | input | 1 | Writeback accepts result |
| out_seq | output | SEQ_W | Sequence number |
| out_ptag | output | TAG_W | Destination physical tag |
| out_pptag | output | TAG_W | Previous physical tag |
| out_wen | output | 1 | Register write enable, always 0 |
| out_taken | output | 1 | Real direction |
| out_target | output | XLEN | PC plus immediate |
| rdr_valid | output | 1 | Misprediction redirect pulse |
| upd_valid | output | 1 | Predictor update pulse |
| nt_taken | output | 1 | Real direction for notifications |
| nt_target | output | XLEN | Taken target for notifications |
| nt_fall | output | XLEN | Fall-through address (PC plus 4) |

## Verification
The hardest case to reach is a mispredicted branch that enters through the bypass path while writeback is stalled. It must publish in that same cycle, then sit in the queue for several cycles without publishing again, and publish nothing further until a later branch reaches the head. Random bursts of low `out_ready` stack up to DEPTH entries and hold heads for varying spans. Operands are often drawn from a small pool of edge values (sign boundary, zero, all ones), so equal and sign-differing comparisons come up often. Directed cases cover each condition code at the signed/unsigned boundary.

// File: rtl/brx_pkg.sv
package brx_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      BK_EQ  = 3'd0,
      BK_NE  = 3'd1,
      BK_RS2 = 3'd2,
      BK_RS3 = 3'd3,
      BK_LT  = 3'd4,
      BK_GE  = 3'd5,
      BK_LTU = 3'd6,
      BK_GEU = 3'd7
   } br_kind_e;
endpackage

// File: rtl/brx_bypass_fifo.sv
module brx_bypass_fifo #(
   parameter int DEPTH = 2,
   parameter int PW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [PW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [PW-1:0] out_data
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("brx_bypass_fifo: DEPTH must be at least 1");
      end
      if (PW < 1) begin : g_bad_pw
         $error("brx_bypass_fifo: PW must be at least 1");
      end
   endgenerate

   logic [PW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          empty, full, pass, store, pop;

   function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign empty     = (cnt == '0);
   assign full      = (cnt == CW'(DEPTH));
   assign in_ready  = !full;
   assign out_valid = !empty || in_valid;
   assign out_data  = empty ? in_data : mem[rd_ptr];
   // Empty queue and a ready consumer: the entry goes straight through.
   assign pass      = empty && in_valid && out_ready;
   assign store     = in_valid && !full && !pass;
   assign pop       = !empty && out_ready;

   always_ff @(posedge clk) begin
      if (store) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (store) wr_ptr <= ptr_next(wr_ptr);
         if (pop)   rd_ptr <= ptr_next(rd_ptr);
         cnt <= cnt + CW'(store) - CW'(pop);
      end
   end

   AST_FIFO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)); // R7
   AST_FIFO_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: rtl/brx_cmp.sv
module brx_cmp
   import brx_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [KIND_W-1:0] kind,
   input  logic [XLEN-1:0]   op_a,
   input  logic [XLEN-1:0]   op_b,
   output logic              taken
);
   logic eq, lt_s, lt_u;

   assign eq = (op_a == op_b);

   generate
      if (SHARED_SUB) begin : g_sub
         // One subtractor: the borrow gives the unsigned order, and the
         // sign bits fix up the signed order.
         logic [XLEN:0] diff;
         assign diff = {1'b0, op_a} - {1'b0, op_b};
         assign lt_u = diff[XLEN];
         assign lt_s = (op_a[XLEN-1] ^ op_b[XLEN-1]) ? op_a[XLEN-1] : lt_u;
      end else begin : g_dual
         assign lt_u = (op_a < op_b);
         assign lt_s = ($signed(op_a) < $signed(op_b));
      end
   endgenerate

   always_comb begin
      case (kind)
         BK_EQ:   taken = eq;
         BK_NE:   taken = !eq;
         BK_LT:   taken = lt_s;
         BK_GE:   taken = !lt_s;
         BK_LTU:  taken = lt_u;
         BK_GEU:  taken = !lt_u;
         default: taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/brx_notify.sv
module brx_notify (
   input  logic clk,
   input  logic rst_n,
   input  logic head_valid,
   input  logic head_ready,
   input  logic mispred,
   output logic rdr_valid,
   output logic upd_valid
);
   logic sent;

   assign upd_valid = head_valid && !sent;
   assign rdr_valid = upd_valid && mispred;

   always_ff @(posedge clk) begin
      if (!rst_n)                        sent <= 1'b0;
      else if (head_valid && head_ready) sent <= 1'b0;
      else if (head_valid)               sent <= 1'b1;
   end

   AST_RDR_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      rdr_valid |-> upd_valid); // R3
   AST_NO_REPUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !head_ready) |=> (!upd_valid && !rdr_valid)); // R5
endmodule

// File: rtl/brx_unit.sv
module brx_unit
   import brx_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int DEPTH      = 2,
   parameter int SEQ_W      = 8,
   parameter int TAG_W      = 6,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [KIND_W-1:0] in_kind,
   input  logic [XLEN-1:0]   in_op_a,
   input  logic [XLEN-1:0]   in_op_b,
   input  logic [XLEN-1:0]   in_pc,
   input  logic [XLEN-1:0]   in_imm,
   input  logic              in_pred,
   input  logic [SEQ_W-1:0]  in_seq,
   input  logic [TAG_W-1:0]  in_ptag,
   input  logic [TAG_W-1:0]  in_pptag,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [SEQ_W-1:0]  out_seq,
   output logic [TAG_W-1:0]  out_ptag,
   output logic [TAG_W-1:0]  out_pptag,
   output logic              out_wen,
   output logic              out_taken,
   output logic [XLEN-1:0]   out_target,
   output logic              rdr_valid,
   output logic              upd_valid,
   output logic              nt_taken,
   output logic [XLEN-1:0]   nt_target,
   output logic [XLEN-1:0]   nt_fall
);
   localparam int PW = KIND_W + 4*XLEN + 1 + SEQ_W + 2*TAG_W;

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("brx_unit: XLEN must be at least 8");
      end
      if (SEQ_W < 1 || TAG_W < 1) begin : g_bad_tags
         $error("brx_unit: SEQ_W and TAG_W must be positive");
      end
   endgenerate

   logic [PW-1:0]     in_bus, head_bus;
   logic [KIND_W-1:0] h_kind;
   logic [XLEN-1:0]   h_a, h_b, h_pc, h_imm, tgt;
   logic              h_pred, taken;

   assign in_bus = {in_kind, in_op_a, in_op_b, in_pc, in_imm, in_pred,
                    in_seq, in_ptag, in_pptag};

   brx_bypass_fifo #(.DEPTH(DEPTH), .PW(PW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_bus),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (head_bus)
   );

   assign {h_kind, h_a, h_b, h_pc, h_imm, h_pred,
           out_seq, out_ptag, out_pptag} = head_bus;

   brx_cmp #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
      .kind  (h_kind),
      .op_a  (h_a),
      .op_b  (h_b),
      .taken (taken)
   );

   brx_notify u_note (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (out_valid),
      .head_ready (out_ready),
      .mispred    (taken != h_pred),
      .rdr_valid  (rdr_valid),
      .upd_valid  (upd_valid)
   );

   assign tgt        = h_pc + h_imm;
   assign out_target = tgt;
   assign out_taken  = taken;
   assign out_wen    = 1'b0;
   assign nt_taken   = taken;
   assign nt_target  = tgt;
   assign nt_fall    = h_pc + XLEN'(4);

   AST_NOTE_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> out_valid); // R4
endmodule

// File: tb/brx_unit_tb_top.sv
module brx_unit_tb_top;
   localparam int DEPTH = 2;

   typedef struct packed {
      logic [2:0]  k;
      logic [31:0] a, b, pc, imm;
      logic        p;
      logic [7:0]  s;
      logic [5:0]  t, u;
   } ins_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, out_ready = 1'b0;
   ins_t cur = '0;
   logic in_ready, out_valid, out_wen, out_taken, rdr_valid, upd_valid, nt_taken;
   logic [7:0]  out_seq;
   logic [5:0]  out_ptag, out_pptag;
   logic [31:0] out_target, nt_target, nt_fall;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   ins_t q[$];
   bit sent_m = 1'b0, in_hs = 1'b0, out_hs = 1'b0;

   always #2 clk = ~clk;

   brx_unit #(.XLEN(32), .DEPTH(DEPTH), .SEQ_W(8), .TAG_W(6)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(cur.k), .in_op_a(cur.a), .in_op_b(cur.b), .in_pc(cur.pc),
      .in_imm(cur.imm), .in_pred(cur.p), .in_seq(cur.s), .in_ptag(cur.t),
      .in_pptag(cur.u), .out_valid(out_valid), .out_ready(out_ready),
      .out_seq(out_seq), .out_ptag(out_ptag), .out_pptag(out_pptag),
      .out_wen(out_wen), .out_taken(out_taken), .out_target(out_target),
      .rdr_valid(rdr_valid), .upd_valid(upd_valid), .nt_taken(nt_taken),
      .nt_target(nt_target), .nt_fall(nt_fall));

   function automatic bit ref_taken(input ins_t i);
      case (i.k)
         3'd0: return i.a == i.b;
         3'd1: return i.a != i.b;
         3'd4: return $signed(i.a) < $signed(i.b);
         3'd5: return $signed(i.a) >= $signed(i.b);
         3'd6: return i.a < i.b;
         3'd7: return i.a >= i.b;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] edge_val();
      case ($urandom_range(0, 7))
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'h7FFF_FFFF;
         4: return 32'h1;
         default: return $urandom();
      endcase
   endfunction

   function automatic ins_t rand_ins(input logic [7:0] seq);
      ins_t i;
      logic [2:0] kinds [6] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
      i.k   = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(2, 3)) : kinds[$urandom_range(0, 5)];
      i.a   = edge_val();
      i.b   = ($urandom_range(0, 3) == 0) ? i.a : edge_val();
      i.pc  = {$urandom()} & 32'hFFFF_FFFC;
      i.imm = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFC : 32'($signed(12'($urandom())));
      i.p   = 1'($urandom());
      i.s   = seq;
      i.t   = 6'($urandom());
      i.u   = 6'($urandom());
      return i;
   endfunction

   // One clock: update the model, drive, then sample at the falling edge.
   task automatic cycle(input bit v, input ins_t ins, input bit ordy);
      bit was_empty;
      @(posedge clk);
      was_empty = (q.size() == 0);
      if (out_hs) begin
         if (!was_empty) void'(q.pop_front());
         sent_m = 1'b0;
      end else if (out_valid) begin
         sent_m = 1'b1;
      end
      if (in_hs && !(was_empty && out_hs)) q.push_back(cur);
      #1;
      in_valid  = v;
      cur       = ins;
      out_ready = ordy;
      @(negedge clk);
      chk("R7 in_ready", {63'b0, in_ready}, {63'b0, q.size() < DEPTH});
      chk("R6 out_valid", {63'b0, out_valid}, {63'b0, (q.size() > 0) || in_valid});
      if (out_valid && ((q.size() > 0) || in_valid)) begin
         ins_t h;
         bit tk;
         h  = (q.size() > 0) ? q[0] : cur;
         tk = ref_taken(h);
         chk("R8 seq", {56'b0, out_seq}, {56'b0, h.s});
         chk("R8 tags", {52'b0, out_ptag, out_pptag}, {52'b0, h.t, h.u});
         chk("R8 wen", {63'b0, out_wen}, 64'd0);
         chk("R1 R10 taken", {62'b0, out_taken, nt_taken}, {62'b0, tk, tk});
         chk("R2 target", {out_target, nt_target}, {h.pc + h.imm, h.pc + h.imm});
         chk("R2 fall", {32'b0, nt_fall}, {32'b0, h.pc + 32'd4});
         chk("R4 R5 upd", {63'b0, upd_valid}, {63'b0, !sent_m});
         chk("R3 R5 rdr", {63'b0, rdr_valid}, {63'b0, !sent_m && (tk != h.p)});
      end else begin
         chk("R3 R4 idle notes", {62'b0, rdr_valid, upd_valid}, 64'd0);
      end
      in_hs  = in_valid && in_ready;
      out_hs = out_valid && out_ready;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      ins_t d;
      logic [7:0] seq = 8'd0;
      void'($urandom(32'd7405));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 reset out_valid", {63'b0, out_valid}, 64'd0);
      chk("R9 reset in_ready", {63'b0, in_ready}, 64'd1);
      chk("R9 reset notes", {62'b0, rdr_valid, upd_valid}, 64'd0);
      rst_n = 1'b1;
      // R1 directed: each code across the sign boundary and equality
      for (int k = 0; k < 8; k++) begin
         for (int c = 0; c < 3; c++) begin
            d = rand_ins(seq++);
            d.k = 3'(k);
            d.a = (c == 0) ? 32'h8000_0000 : (c == 1) ? 32'h7FFF_FFFF : 32'h5;
            d.b = (c == 0) ? 32'h7FFF_FFFF : (c == 1) ? 32'h8000_0000 : 32'h5;
            cycle(1'b1, d, 1'b1);
         end
      end
      // R5 R6 directed: mispredicted branch through bypass under stall
      d = rand_ins(seq++);
      d.k = 3'd0; d.a = 32'h9; d.b = 32'h9; d.p = 1'b0;
      cycle(1'b1, d, 1'b0);
      for (int i = 0; i < 4; i++) cycle(1'b1, rand_ins(seq++), 1'b0);
      for (int i = 0; i < 4; i++) cycle(1'b0, '0, 1'b1);
      // random phase with stall bursts
      for (int i = 0; i < 3000; i++) begin
         bit stall;
         stall = ($urandom_range(0, 9) < 3);
         cycle(($urandom_range(0, 3) != 0), rand_ins(seq), !stall && ($urandom_range(0, 3) != 0));
         if (in_hs) seq++;
      end
      for (int i = 0; i < 6; i++) cycle(1'b0, '0, 1'b1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule